// File: doc/BRIEF.md
# Indexed Generic Clock Generator Bank

This block holds nine programmable clock generators and a set of peripheral clock multiplexers. Every clock is modelled as a one-cycle enable strobe on the single system clock `clk`, so the whole bank is synchronous. Each generator picks a source strobe, divides it by a programmable factor and emits its own strobe stream. Generator 0 always produces the main system strobe. Each peripheral multiplexer forwards the strobes of one chosen generator, and several multiplexers may follow the same generator.

Software configures the bank through three register windows: generator control, generator division and multiplexer control. Each window is one shared word. An ID field carried in every written word names the generator or multiplexer whose private copy is changed. Reading a window returns the copy that was named by the last accepted write to that window. The port has no handshake: a write takes effect on the clock edge where `cfg_we_i` is high. Read data is combinational on `cfg_sel_i`. The block carries no streaming data, so it has no valid/ready interface.

Word layout, common to all windows: bits [7:0] hold the ID. In control words, bits [11:8] hold the select code and bit 16 holds the enable. In division words, bits [8 +: DIV_W] hold the divider. Window codes on `cfg_sel_i` are: 0 for generator control, 1 for division, 2 for multiplexer control, and 3 for none (reads return 0 and writes are dropped). Source codes for generators are: 0–7 select `src_tick_i[code]`, where code 0 is the internal oscillator; 8 selects the output of generator 1; 9–15 select nothing.

Top module: `gclk_bank`

## Requirements
- R1: After reset, generator 0 is enabled with source 0 and divider 8. Generators 1–8 are disabled with source 0 and divider 0. All multiplexers are disabled with generator field 0. All read-back IDs are 0.
- R2: An accepted write changes only the entry named by its ID field. A write whose ID is at or above the entry count of its window is dropped entirely and does not move the read-back ID.
- R3: Reading a window returns, in the write layout, the ID of the last accepted write to that window together with that entry's current fields.
- R4: With a divider of 0 or 1, an enabled generator emits a strobe on the cycle after each strobe of its source.
- R5: With a divider N > 1, an enabled generator emits one strobe per N source strobes, the first one following the N-th source strobe.
- R6: Any accepted write to a generator's control or division word restarts that generator's division count.
- R7: A generator-control write with ID 1 and source code 8 is dropped as a whole. Generator 1 can never select its own output.
- R8: Source code 8 makes a generator count the output strobes of generator 1.
- R9: A disabled generator emits no strobes.
- R10: Each multiplexer forwards, on the same cycle, the strobes of the generator named by bits [11:8] of its control word when bit 16 is set. A disabled multiplexer, or one naming generator 9–15, emits nothing. Several multiplexers may share one generator.
- R11: `main_tick_o` carries exactly the strobes of generator 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick_i | input | 8 | Source clock-enable strobes, bit 0 being the internal oscillator |
| cfg_we_i | input | 1 | Write strobe for the selected window |
| cfg_sel_i | input | 2 | Window select |
| cfg_wdata_i | input | 32 | Write word with ID field |
| cfg_rdata_o | output | 32 | Read-back word of the selected window |
| main_tick_o | output | 1 | Main system strobe (generator 0) |
| gen_tick_o | output | 9 | Strobe of each generator |
| periph_tick_o | output | NUM_MUX | Strobe of each peripheral multiplexer |

## Verification
Several properties are checked on every cycle. Generator 1 never holds its own output as a source. Dropped out-of-range writes leave the enables unchanged. A disabled generator stays silent. An undivided generator answers every input strobe. Each division counter stays below its divider. The main strobe only appears while generator 0 was enabled. Other behaviour is shown only by the bench scenarios, which count strobes over a window: the exact N-to-1 ratios, the count restart after a rewrite, the chaining through generator 1, the reset contents, and the read-back of the last-named entry.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
  localparam int GEN_COUNT    = 9;
  localparam int SRC_IN_COUNT = 8;
  localparam int SEL_W        = 4;
  localparam int ID_W         = 8;
  localparam int GID_W        = $clog2(GEN_COUNT);
  localparam int RESET_DIV    = 8;
  localparam logic [SEL_W-1:0] GEN1_CODE = 4'd8;

  typedef enum logic [1:0] {
    WIN_GENCTRL = 2'd0,
    WIN_GENDIV  = 2'd1,
    WIN_MUXCTRL = 2'd2,
    WIN_NONE    = 2'd3
  } win_e;
endpackage

// File: rtl/gclk_cfg_regs.sv
module gclk_cfg_regs
  import gclk_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int NUM_MUX = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we_i,
  input  win_e                                win_i,
  input  logic [31:0]                         wdata_i,
  output logic [31:0]                         rdata_o,
  output logic [GEN_COUNT-1:0]                gen_en_o,
  output logic [GEN_COUNT-1:0][SEL_W-1:0]     gen_src_o,
  output logic [GEN_COUNT-1:0][DIV_W-1:0]     gen_div_o,
  output logic [GEN_COUNT-1:0]                gen_clr_o,
  output logic [NUM_MUX-1:0]                  mux_en_o,
  output logic [NUM_MUX-1:0][SEL_W-1:0]       mux_gen_o
);
  localparam int MID_W = (NUM_MUX > 1) ? $clog2(NUM_MUX) : 1;

  logic [ID_W-1:0]  wr_id;
  logic [SEL_W-1:0] wr_fld;
  logic             wr_en;
  logic [DIV_W-1:0] wr_div;
  logic             gen_ok, mux_ok, self_bad;
  logic             acc_ctrl, acc_div, acc_mux;
  logic [GID_W-1:0] ptr_ctrl_q, ptr_div_q;
  logic [MID_W-1:0] ptr_mux_q;
  logic             unused_wdata;

  assign wr_id    = wdata_i[ID_W-1:0];
  assign wr_fld   = wdata_i[8 +: SEL_W];
  assign wr_en    = wdata_i[16];
  assign wr_div   = wdata_i[8 +: DIV_W];
  assign unused_wdata = ^wdata_i;

  assign gen_ok   = wr_id < ID_W'(GEN_COUNT);
  assign mux_ok   = wr_id < ID_W'(NUM_MUX);
  assign self_bad = (wr_id == ID_W'(1)) && (wr_fld == GEN1_CODE);
  assign acc_ctrl = we_i && (win_i == WIN_GENCTRL) && gen_ok && !self_bad;
  assign acc_div  = we_i && (win_i == WIN_GENDIV) && gen_ok;
  assign acc_mux  = we_i && (win_i == WIN_MUXCTRL) && mux_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < GEN_COUNT; g++) begin
        gen_en_o[g]  <= (g == 0);
        gen_src_o[g] <= '0;
        gen_div_o[g] <= (g == 0) ? DIV_W'(RESET_DIV) : '0;
      end
      mux_en_o   <= '0;
      mux_gen_o  <= '0;
      ptr_ctrl_q <= '0;
      ptr_div_q  <= '0;
      ptr_mux_q  <= '0;
    end else begin
      if (acc_ctrl) begin
        gen_en_o[wr_id[GID_W-1:0]]  <= wr_en;
        gen_src_o[wr_id[GID_W-1:0]] <= wr_fld;
        ptr_ctrl_q <= wr_id[GID_W-1:0];
      end
      if (acc_div) begin
        gen_div_o[wr_id[GID_W-1:0]] <= wr_div;
        ptr_div_q <= wr_id[GID_W-1:0];
      end
      if (acc_mux) begin
        mux_en_o[wr_id[MID_W-1:0]]  <= wr_en;
        mux_gen_o[wr_id[MID_W-1:0]] <= wr_fld;
        ptr_mux_q <= wr_id[MID_W-1:0];
      end
    end
  end

  always_comb begin
    for (int g = 0; g < GEN_COUNT; g++)
      gen_clr_o[g] = (acc_ctrl || acc_div) && (wr_id == ID_W'(g));
  end

  always_comb begin
    rdata_o = '0;
    case (win_i)
      WIN_GENCTRL: begin
        rdata_o[ID_W-1:0]   = ID_W'(ptr_ctrl_q);
        rdata_o[8 +: SEL_W] = gen_src_o[ptr_ctrl_q];
        rdata_o[16]         = gen_en_o[ptr_ctrl_q];
      end
      WIN_GENDIV: begin
        rdata_o[ID_W-1:0]   = ID_W'(ptr_div_q);
        rdata_o[8 +: DIV_W] = gen_div_o[ptr_div_q];
      end
      WIN_MUXCTRL: begin
        rdata_o[ID_W-1:0]   = ID_W'(ptr_mux_q);
        rdata_o[8 +: SEL_W] = mux_gen_o[ptr_mux_q];
        rdata_o[16]         = mux_en_o[ptr_mux_q];
      end
      default: rdata_o = '0;
    endcase
  end

  // R7
  gen1_no_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_src_o[1] != GEN1_CODE);

  // R2
  bad_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (win_i == WIN_GENCTRL) && (wr_id >= ID_W'(GEN_COUNT))) |=> $stable(gen_en_o));
endmodule

// File: rtl/gclk_gen_div.sv
module gclk_gen_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             clr_i,
  input  logic             in_tick_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             pass;

  assign pass = div_i <= DIV_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (en_i && in_tick_i) begin
        if (pass) begin
          tick_o <= 1'b1;
        end else if (cnt_q == div_i - DIV_W'(1)) begin
          tick_o <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + DIV_W'(1);
        end
      end
    end
  end

  // R9
  disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !tick_o);

  // R4
  passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && in_tick_i && pass && !clr_i) |=> tick_o);

  // R5
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_i > DIV_W'(1)) |-> (cnt_q < div_i));
endmodule

// File: rtl/gclk_periph_mux.sv
module gclk_periph_mux
  import gclk_pkg::*;
(
  input  logic [GEN_COUNT-1:0] gen_tick_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 en_i,
  output logic                 tick_o
);
  always_comb begin
    tick_o = 1'b0;
    for (int g = 0; g < GEN_COUNT; g++)
      if (en_i && (sel_i == SEL_W'(g))) tick_o = gen_tick_i[g];
  end
endmodule

// File: rtl/gclk_bank.sv
module gclk_bank
  import gclk_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int NUM_MUX = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SRC_IN_COUNT-1:0] src_tick_i,
  input  logic                    cfg_we_i,
  input  logic [1:0]              cfg_sel_i,
  input  logic [31:0]             cfg_wdata_i,
  output logic [31:0]             cfg_rdata_o,
  output logic                    main_tick_o,
  output logic [GEN_COUNT-1:0]    gen_tick_o,
  output logic [NUM_MUX-1:0]      periph_tick_o
);
  logic [GEN_COUNT-1:0]            gen_en;
  logic [GEN_COUNT-1:0][SEL_W-1:0] gen_src;
  logic [GEN_COUNT-1:0][DIV_W-1:0] gen_div;
  logic [GEN_COUNT-1:0]            gen_clr;
  logic [GEN_COUNT-1:0]            gen_in;
  logic [NUM_MUX-1:0]              mux_en;
  logic [NUM_MUX-1:0][SEL_W-1:0]   mux_gen;

  gclk_cfg_regs #(.DIV_W(DIV_W), .NUM_MUX(NUM_MUX)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (cfg_we_i),
    .win_i     (win_e'(cfg_sel_i)),
    .wdata_i   (cfg_wdata_i),
    .rdata_o   (cfg_rdata_o),
    .gen_en_o  (gen_en),
    .gen_src_o (gen_src),
    .gen_div_o (gen_div),
    .gen_clr_o (gen_clr),
    .mux_en_o  (mux_en),
    .mux_gen_o (mux_gen)
  );

  for (genvar g = 0; g < GEN_COUNT; g++) begin : g_gen
    always_comb begin
      if (gen_src[g] < SEL_W'(SRC_IN_COUNT))
        gen_in[g] = src_tick_i[gen_src[g][2:0]];
      else if (gen_src[g] == GEN1_CODE)
        gen_in[g] = gen_tick_o[1];
      else
        gen_in[g] = 1'b0;
    end

    gclk_gen_div #(.DIV_W(DIV_W)) div_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (gen_en[g]),
      .div_i     (gen_div[g]),
      .clr_i     (gen_clr[g]),
      .in_tick_i (gen_in[g]),
      .tick_o    (gen_tick_o[g])
    );
  end

  for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
    gclk_periph_mux mux_i (
      .gen_tick_i (gen_tick_o),
      .sel_i      (mux_gen[m]),
      .en_i       (mux_en[m]),
      .tick_o     (periph_tick_o[m])
    );
  end

  assign main_tick_o = gen_tick_o[0];

  // R11
  main_from_gen0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_tick_o |-> $past(gen_en[0]));
endmodule

// File: tb/gclk_bank_tb_top.sv
module gclk_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_tick_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = 2'd3;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        main_tick_o;
  logic [8:0]  gen_tick_o;
  logic [7:0]  periph_tick_o;

  int n_run = 0, n_fail = 0;
  int gcnt [9];
  int pcnt [8];
  int mcnt;

  always #2 clk = ~clk;

  gclk_bank dut_i (
    .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .main_tick_o(main_tick_o),
    .gen_tick_o(gen_tick_o), .periph_tick_o(periph_tick_o)
  );

  function automatic logic [31:0] ctrl_w(int id, int fld, int en);
    return {15'd0, 1'(en), 4'd0, 4'(fld), 8'(id)};
  endfunction
  function automatic logic [31:0] div_w(int id, int dv);
    return {16'd0, 8'(dv), 8'(id)};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(int win, logic [31:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 2'(win); cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0; cfg_sel_i = 2'd3;
  endtask

  task automatic rd_chk(string req, int win, logic [31:0] exp);
    @(negedge clk);
    cfg_sel_i = 2'(win);
    #1 chk(req, int'(cfg_rdata_o), int'(exp));
    cfg_sel_i = 2'd3;
  endtask

  task automatic pulse(logic [7:0] mask, int n);
    foreach (gcnt[i]) gcnt[i] = 0;
    foreach (pcnt[i]) pcnt[i] = 0;
    mcnt = 0;
    for (int i = 0; i < n + 4; i++) begin
      @(negedge clk);
      for (int g = 0; g < 9; g++) gcnt[g] += int'(gen_tick_o[g]);
      for (int m = 0; m < 8; m++) pcnt[m] += int'(periph_tick_o[m]);
      mcnt += int'(main_tick_o);
      src_tick_i = (i < n) ? mask : 8'd0;
    end
    src_tick_i = '0;
  endtask

  task automatic t_reset();
    rd_chk("R1 gen0 ctrl", 0, ctrl_w(0, 0, 1));
    rd_chk("R1 gen0 div", 1, div_w(0, 8));
    rd_chk("R1 mux0", 2, 32'd0);
    chk("R1 outputs idle", int'(gen_tick_o), 0);
    pulse(8'h01, 16);
    chk("R1 R5 gen0 /8", gcnt[0], 2);
    chk("R11 main equals gen0", mcnt, 2);
  endtask

  task automatic t_pass();
    wr(1, div_w(3, 0));
    wr(0, ctrl_w(3, 2, 1));
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); src_tick_i = 8'h04;
      @(negedge clk); src_tick_i = 8'h00;
      chk("R4 div0 strobe next cycle", int'(gen_tick_o[3]), 1);
      @(negedge clk);
      chk("R4 div0 single strobe", int'(gen_tick_o[3]), 0);
    end
    wr(1, div_w(3, 1));
    pulse(8'h04, 7);
    chk("R4 div1 passthrough", gcnt[3], 7);
    wr(0, ctrl_w(9, 5, 0));
    rd_chk("R2 bad id dropped", 0, ctrl_w(3, 2, 1));
    rd_chk("R3 div readback", 1, div_w(3, 1));
    pulse(8'h01, 8);
    chk("R2 gen0 untouched", gcnt[0], 1);
  endtask

  task automatic t_divide();
    wr(0, ctrl_w(4, 3, 1));
    wr(1, div_w(4, 5));
    pulse(8'h08, 20);
    chk("R5 div5", gcnt[4], 4);
    wr(1, div_w(4, 3));
    pulse(8'h08, 10);
    chk("R5 div3", gcnt[4], 3);
  endtask

  task automatic t_restart();
    wr(1, div_w(4, 4));
    pulse(8'h08, 3);
    chk("R6 before rewrite", gcnt[4], 0);
    wr(1, div_w(4, 4));
    pulse(8'h08, 3);
    chk("R6 count restarted", gcnt[4], 0);
    pulse(8'h08, 1);
    chk("R6 fourth strobe", gcnt[4], 1);
  endtask

  task automatic t_gen1();
    wr(0, ctrl_w(1, 1, 1));
    wr(1, div_w(1, 0));
    wr(0, ctrl_w(1, 8, 0));
    rd_chk("R7 self write dropped", 0, ctrl_w(1, 1, 1));
    pulse(8'h02, 4);
    chk("R7 gen1 still running", gcnt[1], 4);
    wr(0, ctrl_w(2, 8, 1));
    wr(1, div_w(2, 2));
    pulse(8'h02, 6);
    chk("R8 gen1 count", gcnt[1], 6);
    chk("R8 gen2 from gen1 /2", gcnt[2], 3);
  endtask

  task automatic t_disabled();
    wr(0, ctrl_w(5, 4, 0));
    pulse(8'h10, 5);
    chk("R9 disabled silent", gcnt[5], 0);
    wr(0, ctrl_w(5, 4, 1));
    pulse(8'h10, 5);
    chk("R9 enabled runs", gcnt[5], 5);
  endtask

  task automatic t_mux();
    wr(2, ctrl_w(0, 3, 1));
    wr(2, ctrl_w(1, 3, 1));
    wr(2, ctrl_w(2, 4, 0));
    wr(2, ctrl_w(3, 0, 1));
    wr(2, ctrl_w(4, 12, 1));
    rd_chk("R3 mux readback", 2, ctrl_w(4, 12, 1));
    pulse(8'h04, 5);
    chk("R10 mux0 shared", pcnt[0], 5);
    chk("R10 mux1 shared", pcnt[1], 5);
    chk("R10 mux2 disabled", pcnt[2], 0);
    pulse(8'h09, 16);
    chk("R10 mux3 follows gen0", pcnt[3], 2);
    chk("R10 mux4 bad gen", pcnt[4], 0);
    chk("R11 main count", mcnt, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pass();
    t_divide();
    t_restart();
    t_gen1();
    t_disabled();
    t_mux();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule